// File: doc/BRIEF.md
# Address-Keyed Audio Bus Channel Mapper

This block is the register window that a signal processor uses to reach an eight-channel, 48 kHz multi-node audio bus. The bus has two master channels (M1, M2) and six slave channels (S1 to S6). A 3-bit node address, taken from configuration switches, decides two things. It decides which bus channels this node puts samples on. It also decides where each channel heard from the other nodes appears in a packed seven-slot read window. The node's own channels are left out of that window.

The processor writes 24-bit words into two transmit slots. On each frame tick (one per 48 kHz period), the upper 16 bits of each slot that the node owns are latched onto the matching per-channel transmit output. The processor reads the receive window through the same synchronous port. Each receive slot returns the status word of the bus channel mapped to it, as supplied by the deserialisers. Slots that are not valid read as zero, and writes to transmit slots that are not valid are dropped. Wire framing, clock generation and the command link are outside this block.

Top module: `ab_chan_mapper`

## Requirements
- R1: While rst_ni is low, tx_drive_o, tx_data_o and rd_valid_o are all zero, and the sampled address is treated as 7 (drives nothing).
- R2: node_addr_i is registered every clock, and the mapping follows that register one cycle later. Channel index c of tx_drive_o and tx_data_o is M1 for c=0, M2 for c=1, and S(c-1) for c=2..7. Address 0 drives channels 0 and 1, address a in 1..6 drives channel a+1 only, and address 7 drives none.
- R3: On a clock where frame_tick_i is high, each owned channel latches bits 23:8 of its transmit slot and each channel that is not owned latches zero. The latched value appears on tx_data_o the next cycle and holds until the next tick. Address 0 maps slot 0 to M1 and slot 1 to M2; addresses 1..6 map slot 0 to their own slave channel. A slot write on the tick clock itself is sent at the following tick.
- R4: When several writes hit one transmit slot within one frame period, the last one is sent.
- R5: Receive slots 0..6 sit at req_addr_i 0..6. They hold, in ascending order, the slave channels the node does not drive, followed by M1 then M2 when the address is not 0. S6 is not listed at address 0 or at address 7, so the master sees S1..S5 and address 7 sees S1..S5, M1, M2. A read of a valid receive slot returns the mapped channel's 22-bit status word, zero-extended to 24 bits.
- R6: A read returns zero for a receive slot beyond the list (slots 5 and 6 at address 0), for req_addr_i 7 and 10..15, and for a transmit slot that is not valid at the current address.
- R7: Transmit slot 0 sits at req_addr_i 8 and slot 1 at 9. A slot is valid at address 0 (both slots) and at addresses 1..6 (slot 0 only); at address 7 no slot is valid. Writes to a slot that is not valid, and writes to any receive address, leave all stored state unchanged.
- R8: A read request (req_valid_i high, req_write_i low) gives rd_valid_o high with rd_data_o on the next cycle. Any other cycle gives rd_valid_o low. A valid transmit slot reads back its full 24-bit stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_addr_i | input | 3 | Node address from configuration switches |
| frame_tick_i | input | 1 | One-clock strobe at the start of each 48 kHz period |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Register address (0..6 receive slots, 8..9 transmit slots) |
| req_wdata_i | input | 24 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 24 | Read data |
| rx_word_i | input | 176 | Per-channel received status words, 22 bits each, channel c at bits 22c+21:22c |
| tx_data_o | output | 128 | Per-channel transmit samples, 16 bits each, channel c at bits 16c+15:16c |
| tx_drive_o | output | 8 | Per-channel drive enable for this node |

## Verification
A processor write to a transmit slot can land on the same clock as the frame tick that latches that slot onto the bus. The bench provokes this by raising frame_tick_i together with a slot-0 write at the master address. It judges the result in two steps: the wire must still carry the previous sample right after that tick, and it must carry the new sample only after the following tick. A scoreboard queues the expected read word for every read issued across all eight addresses. A monitor compares each returned word in arrival order. Because the window is remapped and the stored slot state survives address changes, the same checks also show that writes dropped under one address never reach storage.

// File: rtl/ab_map_pkg.sv
package ab_map_pkg;
  localparam int N_CH      = 8;
  localparam int N_TX_SLOT = 2;
  localparam int N_RX_SLOT = 7;
  localparam int N_SLAVE   = 6;
  localparam int TX_IDX_W  = $clog2(N_TX_SLOT);

  typedef struct packed {
    logic       ok;
    logic [2:0] ch;
  } rx_sel_t;

  typedef struct packed {
    logic                ok;
    logic [TX_IDX_W-1:0] slot;
  } tx_own_t;

  // slave channel left out of the window: own one, or S6 for master/listener
  function automatic int excluded_slave(input logic [2:0] a);
    if (a >= 3'd1 && a <= 3'd5) return int'(a);
    return N_SLAVE;
  endfunction

  function automatic rx_sel_t rx_select(input logic [2:0] a, input int slot);
    rx_sel_t r;
    int      s;
    r = '0;
    if (slot < N_SLAVE - 1) begin
      s = slot + 1;
      if (s >= excluded_slave(a)) s = s + 1;
      r.ok = 1'b1;
      r.ch = 3'(s + 1);
    end else if (slot < N_RX_SLOT && a != 3'd0) begin
      r.ok = 1'b1;
      r.ch = 3'(slot - (N_SLAVE - 1));
    end
    return r;
  endfunction

  function automatic logic tx_slot_ok(input logic [2:0] a, input int slot);
    if (a == 3'd0) return slot < N_TX_SLOT;
    if (a <= 3'd6) return slot == 0;
    return 1'b0;
  endfunction

  function automatic tx_own_t tx_owner(input logic [2:0] a, input int ch);
    tx_own_t o;
    o = '0;
    if (a == 3'd0 && ch < N_TX_SLOT) begin
      o.ok   = 1'b1;
      o.slot = TX_IDX_W'(ch);
    end else if (a >= 3'd1 && a <= 3'd6 && ch == int'(a) + 1) begin
      o.ok = 1'b1;
    end
    return o;
  endfunction
endpackage

// File: rtl/ab_addr_map.sv
module ab_addr_map
  import ab_map_pkg::*;
(
  input  logic [2:0]                     addr_i,
  output rx_sel_t [N_RX_SLOT-1:0]        rx_sel_o,
  output tx_own_t [N_CH-1:0]             tx_own_o,
  output logic    [N_TX_SLOT-1:0]        tx_slot_ok_o
);
  for (genvar k = 0; k < N_RX_SLOT; k++) begin : g_rx
    assign rx_sel_o[k] = rx_select(addr_i, k);
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_own
    assign tx_own_o[c] = tx_owner(addr_i, c);
  end

  for (genvar t = 0; t < N_TX_SLOT; t++) begin : g_slot
    assign tx_slot_ok_o[t] = tx_slot_ok(addr_i, t);
  end
endmodule

// File: rtl/ab_tx_slots.sv
module ab_tx_slots
  import ab_map_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int SAMPLE_W = 16
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [TX_IDX_W-1:0]                  wr_slot_i,
  input  logic [DATA_W-1:0]                    wr_data_i,
  input  logic                                 tick_i,
  input  tx_own_t [N_CH-1:0]                   own_i,
  output logic [N_TX_SLOT-1:0][DATA_W-1:0]     slot_q_o,
  output logic [N_CH*SAMPLE_W-1:0]             wire_o
);
  logic [N_TX_SLOT-1:0][DATA_W-1:0] slot_q;
  logic [N_CH-1:0][SAMPLE_W-1:0]    wire_q;

  for (genvar t = 0; t < N_TX_SLOT; t++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[t] <= '0;
      else if (wr_en_i && wr_slot_i == TX_IDX_W'(t)) slot_q[t] <= wr_data_i;
    end
  end

  // tick reads the pre-edge slot value; a same-clock write goes out next period
  for (genvar c = 0; c < N_CH; c++) begin : g_wire
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wire_q[c] <= '0;
      else if (tick_i) begin
        if (own_i[c].ok) wire_q[c] <= slot_q[own_i[c].slot][DATA_W-1 -: SAMPLE_W];
        else             wire_q[c] <= '0;
      end
    end
    assign wire_o[c*SAMPLE_W +: SAMPLE_W] = wire_q[c];
  end

  assign slot_q_o = slot_q;
endmodule

// File: rtl/ab_rx_window.sv
module ab_rx_window
  import ab_map_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int STAT_W = 22
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             rd_en_i,
  input  logic [3:0]                       rd_addr_i,
  input  rx_sel_t [N_RX_SLOT-1:0]          rx_sel_i,
  input  logic [N_CH*STAT_W-1:0]           rx_word_i,
  input  logic [N_TX_SLOT-1:0][DATA_W-1:0] slot_q_i,
  input  logic [N_TX_SLOT-1:0]             slot_ok_i,
  output logic                             rd_valid_o,
  output logic [DATA_W-1:0]                rd_data_o
);
  rx_sel_t           sel;
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    sel    = '0;
    rd_nxt = '0;
    if (!rd_addr_i[3]) begin
      for (int k = 0; k < N_RX_SLOT; k++)
        if (rd_addr_i[2:0] == 3'(k)) sel = rx_sel_i[k];
      if (sel.ok)
        for (int c = 0; c < N_CH; c++)
          if (sel.ch == 3'(c)) rd_nxt[STAT_W-1:0] = rx_word_i[c*STAT_W +: STAT_W];
    end else begin
      for (int t = 0; t < N_TX_SLOT; t++)
        if (rd_addr_i[2:0] == 3'(t) && slot_ok_i[t]) rd_nxt = slot_q_i[t];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_nxt;
    end
  end
endmodule

// File: rtl/ab_chan_mapper.sv
module ab_chan_mapper
  import ab_map_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int SAMPLE_W = 16,
  parameter int STAT_W   = 22
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [2:0]                 node_addr_i,
  input  logic                       frame_tick_i,
  input  logic                       req_valid_i,
  input  logic                       req_write_i,
  input  logic [3:0]                 req_addr_i,
  input  logic [DATA_W-1:0]          req_wdata_i,
  output logic                       rd_valid_o,
  output logic [DATA_W-1:0]          rd_data_o,
  input  logic [N_CH*STAT_W-1:0]     rx_word_i,
  output logic [N_CH*SAMPLE_W-1:0]   tx_data_o,
  output logic [N_CH-1:0]            tx_drive_o
);
  logic [2:0]                       addr_q;
  rx_sel_t [N_RX_SLOT-1:0]          rx_sel;
  tx_own_t [N_CH-1:0]               tx_own;
  logic [N_TX_SLOT-1:0]             slot_ok;
  logic [N_TX_SLOT-1:0][DATA_W-1:0] slot_q;
  logic                             wr_en;
  logic                             rd_en;
  logic                             wr_slot_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= 3'd7;
    else         addr_q <= node_addr_i;
  end

  ab_addr_map u_map (
    .addr_i       (addr_q),
    .rx_sel_o     (rx_sel),
    .tx_own_o     (tx_own),
    .tx_slot_ok_o (slot_ok)
  );

  always_comb begin
    wr_slot_hit = 1'b0;
    for (int t = 0; t < N_TX_SLOT; t++)
      if (req_addr_i == {1'b1, 3'(t)} && slot_ok[t]) wr_slot_hit = 1'b1;
  end

  assign wr_en = req_valid_i && req_write_i && wr_slot_hit;
  assign rd_en = req_valid_i && !req_write_i;

  ab_tx_slots #(.DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_slot_i (req_addr_i[TX_IDX_W-1:0]),
    .wr_data_i (req_wdata_i),
    .tick_i    (frame_tick_i),
    .own_i     (tx_own),
    .slot_q_o  (slot_q),
    .wire_o    (tx_data_o)
  );

  ab_rx_window #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en),
    .rd_addr_i  (req_addr_i),
    .rx_sel_i   (rx_sel),
    .rx_word_i  (rx_word_i),
    .slot_q_i   (slot_q),
    .slot_ok_i  (slot_ok),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_drive
    assign tx_drive_o[c] = tx_own[c].ok;
  end
endmodule

// File: rtl/ab_chan_mapper_chk.sv
module ab_chan_mapper_chk #(
  parameter int N_CH     = 8,
  parameter int DATA_W   = 24,
  parameter int SAMPLE_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [2:0]               addr_q,
  input logic                     frame_tick_i,
  input logic                     req_valid_i,
  input logic                     req_write_i,
  input logic [3:0]               req_addr_i,
  input logic                     rd_valid_o,
  input logic [DATA_W-1:0]        rd_data_o,
  input logic [N_CH*SAMPLE_W-1:0] tx_data_o,
  input logic [N_CH-1:0]          tx_drive_o
);
  a_r2_slave_one_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_q >= 3'd1 && addr_q <= 3'd6) |-> $onehot(tx_drive_o));

  a_r2_master_two_channels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_q == 3'd0) |-> ($countones(tx_drive_o) == 2));

  a_r2_listener_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_q == 3'd7) |-> (tx_drive_o == '0));

  a_r3_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_tick_i |=> $stable(tx_data_o));

  a_r3_listener_sends_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_tick_i && addr_q == 3'd7) |=> (tx_data_o == '0));

  a_r8_read_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rd_valid_o);

  a_r8_no_spurious_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i || req_write_i) |=> !rd_valid_o);

  a_r6_empty_address_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_addr_i == 4'd7) |=> (rd_data_o == '0));
endmodule

bind ab_chan_mapper ab_chan_mapper_chk #(
  .N_CH(8), .DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_q       (addr_q),
  .frame_tick_i (frame_tick_i),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .req_addr_i   (req_addr_i),
  .rd_valid_o   (rd_valid_o),
  .rd_data_o    (rd_data_o),
  .tx_data_o    (tx_data_o),
  .tx_drive_o   (tx_drive_o)
);

// File: tb/ab_chan_mapper_bench.sv
`timescale 1ns/1ps
module ab_chan_mapper_bench;
  localparam int NCH = 8;
  localparam int SW  = 22;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [2:0]      node_addr_i = 3'd0;
  logic            frame_tick_i = 1'b0;
  logic            req_valid_i = 1'b0;
  logic            req_write_i = 1'b0;
  logic [3:0]      req_addr_i = 4'd0;
  logic [23:0]     req_wdata_i = 24'd0;
  logic            rd_valid_o;
  logic [23:0]     rd_data_o;
  logic [NCH*SW-1:0] rx_word_i;
  logic [NCH*16-1:0] tx_data_o;
  logic [NCH-1:0]  tx_drive_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk_i = ~clk_i;

  ab_chan_mapper u_ab_chan_mapper (
    .clk_i(clk_i), .rst_ni(rst_ni), .node_addr_i(node_addr_i),
    .frame_tick_i(frame_tick_i), .req_valid_i(req_valid_i),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .rx_word_i(rx_word_i),
    .tx_data_o(tx_data_o), .tx_drive_o(tx_drive_o)
  );

  function automatic logic [SW-1:0] rxw(int c);
    return {4'(c), 1'b1, 1'b0, 16'hC0DE ^ 16'(c * 16'h1111)};
  endfunction

  initial for (int c = 0; c < NCH; c++) rx_word_i[c*SW +: SW] = rxw(c);

  // window model: list of channel indices seen by node a
  function automatic logic [23:0] exp_rx(int a, int slot);
    int lst[$];
    for (int s = 1; s <= 6; s++) begin
      if (s == a) continue;
      if (s == 6 && (a == 0 || a == 7)) continue;
      lst.push_back(s + 1);
    end
    if (a != 0) begin lst.push_back(0); lst.push_back(1); end
    if (slot < lst.size()) return 24'(rxw(lst[slot]));
    return 24'd0;
  endfunction

  function automatic logic [7:0] exp_mask(int a);
    if (a == 0) return 8'b0000_0011;
    if (a <= 6) return 8'(1 << (a + 1));
    return 8'd0;
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_addr(int a);
    @(negedge clk_i) node_addr_i = 3'(a);
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(logic [3:0] ad, logic [23:0] d);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = ad; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] ad, logic [23:0] e, string tag);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = ad;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk_i) frame_tick_i = 1'b1;
    @(negedge clk_i) frame_tick_i = 1'b0;
  endtask

  // monitor: compare every returned word against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected read reply", 128'(rd_data_o), 128'd0);
      else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(rd_data_o == e, t, 128'(rd_data_o), 128'(e));
      end
    end
  end

  logic [23:0] d0 [8];
  logic [23:0] d1 [8];

  initial begin
    repeat (3) @(negedge clk_i);
    check(tx_drive_o == '0, "R1 reset drive", 128'(tx_drive_o), 128'd0);
    check(tx_data_o == '0, "R1 reset tx data", 128'(tx_data_o), 128'd0);
    check(rd_valid_o == 1'b0, "R1 reset rd_valid", 128'(rd_valid_o), 128'd0);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int a = 0; a < 8; a++) begin
      d0[a] = {8'(a) + 8'h30, 8'hA5 ^ 8'(a), 8'h5C};
      d1[a] = {8'(a) + 8'h60, 8'h3C, 8'hF1};
      set_addr(a);
      check(tx_drive_o == exp_mask(a), $sformatf("R2 drive mask addr %0d", a),
            128'(tx_drive_o), 128'(exp_mask(a)));
      wr(4'd8, d0[a]);
      wr(4'd9, d1[a]);
      tick();
      for (int c = 0; c < NCH; c++) begin
        logic [15:0] e;
        e = 16'd0;
        if (a == 0 && c == 0) e = d0[a][23:8];
        if (a == 0 && c == 1) e = d1[a][23:8];
        if (a >= 1 && a <= 6 && c == a + 1) e = d0[a][23:8];
        check(tx_data_o[c*16 +: 16] == e, $sformatf("R3 addr %0d ch %0d", a, c),
              128'(tx_data_o[c*16 +: 16]), 128'(e));
      end
      for (int s = 0; s < 7; s++)
        rd(4'(s), exp_rx(a, s), $sformatf("R5 addr %0d slot %0d", a, s));
      rd(4'd8, (a <= 6) ? d0[a] : 24'd0, $sformatf("R8 slot0 readback addr %0d", a));
      rd(4'd9, (a == 0) ? d1[a] : 24'd0, $sformatf("R6 slot1 addr %0d", a));
      rd(4'd7, 24'd0, "R6 empty address 7");
      rd(4'hC, 24'd0, "R6 empty address 12");
    end

    // state written under addresses 1..7 must not reach the dropped slots
    set_addr(0);
    rd(4'd9, d1[0], "R7 slot1 kept through slave addresses");
    rd(4'd8, d0[6], "R7 slot0 kept through address 7");
    wr(4'd3, 24'hFFFFFF);
    rd(4'd3, exp_rx(0, 3), "R7 write to receive address ignored");

    wr(4'd8, 24'h123456);
    wr(4'd8, 24'hABCDEF);
    tick();
    check(tx_data_o[15:0] == 16'hABCD, "R4 last write wins", 128'(tx_data_o[15:0]), 128'hABCD);

    // write and tick on the same clock
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 4'd8; req_wdata_i = 24'h5A5A00;
    frame_tick_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0; frame_tick_i = 1'b0;
    check(tx_data_o[15:0] == 16'hABCD, "R3 same-clock write not yet sent",
          128'(tx_data_o[15:0]), 128'hABCD);
    repeat (4) @(negedge clk_i);
    check(tx_data_o[15:0] == 16'hABCD, "R3 hold between ticks", 128'(tx_data_o[15:0]), 128'hABCD);
    check(rd_valid_o == 1'b0, "R8 no reply without read", 128'(rd_valid_o), 128'd0);
    tick();
    check(tx_data_o[15:0] == 16'h5A5A, "R3 same-clock write sent next tick",
          128'(tx_data_o[15:0]), 128'h5A5A);

    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R8 all reads answered", 128'(exp_q.size()), 128'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule